// File: doc/BRIEF.md
# Converter Result Byte-Pair Register

This block stores the 10-bit output of an analog-to-digital converter and lets an 8-bit processor bus read it as two read-only bytes, one at a low address and one at a high address. The converter is modelled as a strobe that marks a finished conversion, together with the 10-bit value. A control bit picks the layout of the value inside the 16-bit pair. Clearing it packs the value against bit 0. Setting it packs the value against bit 15, so the top eight bits can be fetched with one access.

To keep the two halves consistent, a read of the low byte freezes the visible result until the high byte is read. A conversion that finishes while the result is frozen waits in a single pending slot, and only the newest one is kept. That slot is copied into view when the high-byte read releases the freeze. Results taken from differential inputs are two's complement numbers. They pass through unchanged, and bit 9 is the sign. Read data is combinational from the visible result and the current layout bit.

Top module: `adc_result_regs`

## Requirements
- R1: After a synchronous reset, reads at both byte addresses return 0x00.
- R2: With `left_align` = 0, the low byte (address 0) returns result bits 7:0. The high byte (address 1) returns bits 9:8 in its bits 1:0, and its bits 7:2 read 0.
- R3: With `left_align` = 1, the high byte returns result bits 9:2. The low byte returns bits 1:0 in its bits 7:6, and its bits 5:0 read 0.
- R4: Once the low byte has been read, later strobes do not change the visible result until the high byte is read, so the high byte belongs to the same conversion as the low byte.
- R5: A read of the high byte alone does not freeze the result, and the next strobe updates the visible result on its edge.
- R6: A strobe that arrives while the result is frozen goes into a single pending slot. A later strobe overwrites that slot. The slot becomes visible on the clock edge of the high-byte read that releases the freeze.
- R7: A strobe in the same cycle as a releasing high-byte read loads its new value on that edge, and any pending value is discarded. A strobe in the same cycle as a low-byte read goes to the pending slot.
- R8: Changing `left_align` changes the bytes returned in the same cycle, with no new conversion needed, even while the result is frozen.
- R9: Write cycles (`bus_wr` = 1) never change the stored result and never freeze or release it. A cycle with both `bus_rd` and `bus_wr` set counts as a write.
- R10: Two's complement results are stored verbatim. With `left_align` = 1, result bit 9 (the sign) appears as bit 7 of the high byte.
- R11: `bus_rdata` is 0x00 when no read is active or when the read address is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data | input | 10 | Converter result, valid with `conv_done` |
| left_align | input | 1 | 1 packs the result against bit 15, 0 against bit 0 |
| bus_addr | input | 2 | Byte address: 0 is the low byte, 1 is the high byte |
| bus_rd | input | 1 | Read strobe for the addressed byte |
| bus_wr | input | 1 | Write strobe; the block ignores the write |
| bus_rdata | output | 8 | Read data, combinational |

## Verification
The assertions assume that `conv_done` and the bus strobes are clean, single-cycle-per-access signals sampled on the rising edge. They also assume that a read and a write in the same cycle are resolved as a write, and that `conv_data` matters only while `conv_done` is high. The stimulus drives every input half a cycle away from the active edge. It draws strobes, addresses, layout changes and overlapping reads and writes from a seeded random source. It also covers addresses outside the two bytes and cycles with both strobes set. Directed sequences force the orderings that random traffic reaches rarely: a strobe landing on the same edge as a releasing read or a freezing read, two strobes arriving during one freeze, and a change of layout while frozen.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

  // which byte of the pair a bus cycle targets
  typedef enum logic [1:0] {
    BSEL_NONE = 2'd0,
    BSEL_LO   = 2'd1,
    BSEL_HI   = 2'd2
  } byte_sel_e;

endpackage

// File: rtl/adc_res_hold.sv
// Visible result plus one-deep pending slot, guarded by a read-order freeze.
module adc_res_hold #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             lo_rd,
  input  logic             hi_rd,
  output logic [RES_W-1:0] vis_q
);

  logic [RES_W-1:0] pend_q;
  logic             pend_vld_q;
  logic             frozen_q;
  logic             hold_now;

  // a low read in this cycle already counts as frozen; a high read releases
  assign hold_now = (frozen_q || lo_rd) && !hi_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      frozen_q   <= 1'b0;
    end else begin
      if (conv_done) begin
        if (hold_now) begin
          pend_q     <= conv_data;
          pend_vld_q <= 1'b1;
        end else begin
          vis_q      <= conv_data;
          pend_vld_q <= 1'b0;
        end
      end else if (frozen_q && hi_rd && pend_vld_q) begin
        vis_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end

      if (hi_rd) begin
        frozen_q <= 1'b0;
      end else if (lo_rd) begin
        frozen_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_res_align.sv
// Presents the stored result in the selected layout on the byte bus.
module adc_res_align
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              left_align,
  input  byte_sel_e         sel,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAIR_W = 2 * DATA_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (left_align) pair = {res, {PAD_W{1'b0}}};
        else            pair = {{PAD_W{1'b0}}, res};
      end
    end else begin : g_full
      always_comb pair = res;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      BSEL_LO: rdata = pair[DATA_W-1:0];
      BSEL_HI: rdata = pair[PAIR_W-1:DATA_W];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_align,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  logic             rd_en;
  logic             lo_rd;
  logic             hi_rd;
  byte_sel_e        sel;
  logic [RES_W-1:0] vis_q;

  assign rd_en = bus_rd && !bus_wr;
  assign lo_rd = rd_en && (bus_addr == LO_A);
  assign hi_rd = rd_en && (bus_addr == HI_A);

  always_comb begin
    if (lo_rd)      sel = BSEL_LO;
    else if (hi_rd) sel = BSEL_HI;
    else            sel = BSEL_NONE;
  end

  adc_res_hold #(
    .RES_W (RES_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .lo_rd     (lo_rd),
    .hi_rd     (hi_rd),
    .vis_q     (vis_q)
  );

  adc_res_align #(
    .RES_W  (RES_W),
    .DATA_W (DATA_W)
  ) u_align (
    .res        (vis_q),
    .left_align (left_align),
    .sel        (sel),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
  parameter int RES_W   = 10,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_align,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [RES_W-1:0]  vis
);

  logic c_lo, c_hi, c_lock;

  assign c_lo = bus_rd && !bus_wr && (bus_addr == ADDR_W'(LO_ADDR));
  assign c_hi = bus_rd && !bus_wr && (bus_addr == ADDR_W'(HI_ADDR));

  always_ff @(posedge clk) begin
    if (rst)       c_lock <= 1'b0;
    else if (c_hi) c_lock <= 1'b0;
    else if (c_lo) c_lock <= 1'b1;
  end

  // R4: frozen result stays put until the releasing high read
  a_r4_frozen_stable: assert property (@(posedge clk) disable iff (rst)
    ((c_lock || c_lo) && !c_hi) |=> $stable(vis));

  // R5 / R7: unfrozen strobe loads on its edge
  a_r5_load_unfrozen: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !c_lo && (!c_lock || c_hi)) |=> (vis == $past(conv_data)));

  // R2: right layout keeps high byte upper bits clear
  a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (c_hi && !left_align) |-> (bus_rdata[DATA_W-1:2] == '0));

  // R3: left layout keeps low byte lower bits clear
  a_r3_lo_lower_zero: assert property (@(posedge clk) disable iff (rst)
    (c_lo && left_align) |-> (bus_rdata[5:0] == '0));

  // R9: a write cycle with no strobe leaves the result alone
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !conv_done) |=> $stable(vis));

  // R11: no active read means zero data
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!c_lo && !c_hi) |-> (bus_rdata == '0));

endmodule

bind adc_result_regs adc_result_regs_chk #(
  .RES_W   (RES_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .LO_ADDR (LO_ADDR),
  .HI_ADDR (HI_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .left_align (left_align),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .vis        (vis_q)
);

// File: tb/adc_result_regs_tb.sv
module adc_result_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       conv_done;
  logic [9:0] conv_data;
  logic       left_align;
  logic [1:0] bus_addr;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // requirement-level reference state
  logic [9:0] m_vis, m_pend;
  bit         m_pv, m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_regs u_dut (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .left_align (left_align),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata)
  );

  function automatic logic [7:0] exp_byte(input logic [9:0] r, input bit la,
                                          input bit rd, input bit wr,
                                          input logic [1:0] a);
    logic [15:0] p;
    p = la ? {r, 6'b0} : {6'b0, r};
    if (!rd || wr) return 8'h00;
    if (a == 2'd0) return p[7:0];
    if (a == 2'd1) return p[15:8];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit cv, input logic [9:0] d, input bit rd, input bit wr,
                      input logic [1:0] a, input bit la, input string tag);
    bit lo, hi, hold;
    @(negedge clk);
    conv_done = cv; conv_data = d; bus_rd = rd; bus_wr = wr;
    bus_addr = a; left_align = la;
    #1;
    check(tag, bus_rdata, exp_byte(m_vis, la, rd, wr, a));
    @(posedge clk);
    lo   = rd && !wr && (a == 2'd0);
    hi   = rd && !wr && (a == 2'd1);
    hold = (m_lock || lo) && !hi;
    if (cv) begin
      if (hold) begin m_pend = d; m_pv = 1; end
      else      begin m_vis = d;  m_pv = 0; end
    end else if (m_lock && hi && m_pv) begin
      m_vis = m_pend; m_pv = 0;
    end
    if (hi)      m_lock = 0;
    else if (lo) m_lock = 1;
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit la;
    rst = 1; conv_done = 0; conv_data = '0; left_align = 0;
    bus_addr = '0; bus_rd = 0; bus_wr = 0;
    m_vis = '0; m_pend = '0; m_pv = 0; m_lock = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset value
    step(0, 0, 1, 0, 2'd1, 0, "R1");
    step(0, 0, 1, 0, 2'd0, 0, "R1");
    step(0, 0, 1, 0, 2'd1, 0, "R1");

    // R2 right layout: 2A5 -> lo A5, hi 02
    step(1, 10'h2A5, 0, 0, 2'd0, 0, "R11");
    step(0, 0, 1, 0, 2'd0, 0, "R2");
    step(0, 0, 1, 0, 2'd1, 0, "R2");

    // R3 / R8 left layout, same stored value: hi A9, lo 40
    step(0, 0, 1, 0, 2'd1, 1, "R8");
    step(0, 0, 1, 0, 2'd0, 1, "R3");
    step(0, 0, 1, 0, 2'd1, 1, "R3");

    // R4 / R6 freeze with two strobes, newest pending wins
    step(0, 0, 1, 0, 2'd0, 0, "R4");
    step(1, 10'h155, 0, 0, 2'd0, 0, "R4");
    step(1, 10'h0F0, 0, 0, 2'd0, 0, "R6");
    step(0, 0, 1, 0, 2'd0, 1, "R8");
    step(0, 0, 1, 0, 2'd1, 0, "R4");
    step(0, 0, 1, 0, 2'd1, 0, "R6");
    step(0, 0, 1, 0, 2'd0, 0, "R6");
    step(0, 0, 1, 0, 2'd1, 0, "R6");

    // R5 high-only read does not freeze
    step(0, 0, 1, 0, 2'd1, 1, "R5");
    step(1, 10'h3FF, 0, 0, 2'd0, 1, "R5");
    step(0, 0, 1, 0, 2'd1, 1, "R5");

    // R7 strobe with releasing high read: new value wins over pending
    step(0, 0, 1, 0, 2'd0, 0, "R7");
    step(1, 10'h111, 0, 0, 2'd0, 0, "R7");
    step(1, 10'h222, 1, 0, 2'd1, 0, "R7");
    step(0, 0, 1, 0, 2'd1, 0, "R7");
    // R7 strobe with low read goes pending
    step(1, 10'h333, 1, 0, 2'd0, 0, "R7");
    step(0, 0, 1, 0, 2'd1, 0, "R7");
    step(0, 0, 1, 0, 2'd1, 0, "R7");

    // R9 writes, including read+write, change nothing and return 0
    step(0, 0, 1, 1, 2'd0, 0, "R9");
    step(0, 0, 0, 1, 2'd1, 0, "R9");
    step(1, 10'h0AA, 0, 0, 2'd0, 0, "R9");
    step(0, 0, 1, 0, 2'd0, 0, "R9");
    step(0, 0, 1, 1, 2'd1, 0, "R9");
    step(0, 0, 1, 0, 2'd0, 0, "R9");
    step(0, 0, 1, 0, 2'd1, 0, "R9");

    // R10 most negative two's complement, left: hi 80
    step(1, 10'h200, 0, 0, 2'd0, 1, "R10");
    step(0, 0, 1, 0, 2'd1, 1, "R10");
    step(1, 10'h3FE, 0, 0, 2'd0, 1, "R10");
    step(0, 0, 1, 0, 2'd1, 1, "R10");

    // R11 unmapped addresses and idle
    step(0, 0, 1, 0, 2'd2, 0, "R11");
    step(0, 0, 1, 0, 2'd3, 1, "R11");
    step(0, 0, 0, 0, 2'd1, 1, "R11");

    // random traffic
    void'($urandom(32'h5EED_A11C));
    la = 0;
    for (int i = 0; i < 4000; i++) begin
      bit cv, rd, wr;
      logic [1:0] a;
      string t;
      cv = ($urandom_range(0, 3) == 0);
      rd = ($urandom_range(0, 2) != 0);
      wr = ($urandom_range(0, 9) == 0);
      a  = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) la = !la;
      if (m_lock)        t = "R4";
      else if (!rd || wr) t = "R11";
      else if (la)       t = "R3";
      else               t = "R2";
      step(cv, 10'($urandom), rd, wr, a, la, t);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule